// File: doc/BRIEF.md
# Three-Phase Triangle-Carrier PWM Generator

This block drives the upper and lower switches of three inverter legs. A single up/down counter forms a symmetric triangle carrier running from zero to a programmable peak and back to zero. Each leg compares its own reference against that carrier. The result becomes a complementary pair of gate signals, and every turn-on edge is held back by a programmable dead time.

Two timing events come out of the carrier. The first fires when the falling slope reaches a programmable compare-down level, so the processor gets a warning a known time before the switching cycle ends. The second fires when the carrier returns to zero, which marks the start of a new cycle. Each event sets a sticky pending bit, and each pending bit can be routed to one interrupt line.

All settings are written through a small write-only register port. New references go into shadow registers and are applied only at the cycle boundary, so a leg never switches on a half-updated reference. As an example of the timing, a count clock of 7.5 MHz with a peak of 750 and a prescale of 1 gives a 5 kHz carrier. At that rate, one dead-time count is 133 ns, and a compare-down level of 120 fires 16 µs before the next zero.

Top module: `pwm3_gen`

## Requirements
- R1: While running with peak P ≥ 1, the carrier rises by one per tick from 0 to P and then falls by one per tick back to 0, so one cycle is 2·P ticks. The first tick comes on the first clock edge after the run bit is set. A peak of 0 holds the carrier at 0.
- R2: A tick occurs once every N clocks, where N is the prescale register. A prescale value of 0 behaves as 1.
- R3: The register write port uses these word addresses: 0 control (bit0 run, bit1 compare-down interrupt enable, bit2 zero interrupt enable), 1 peak, 2 prescale, 3 dead time, 4 compare-down level, 5/6/7 references of legs 0/1/2, 8 pending clear (bit0 compare-down, bit1 zero; a 1 clears).
- R4: `evt_cmp_down` pulses for one clock in the cycle where a falling step of the carrier lands on the compare-down level. A rising step never fires it.
- R5: `evt_zero` pulses for one clock in the cycle where a falling step lands on 0.
- R6: A written reference takes effect at the next falling step onto 0. While stopped, references take effect on the next clock.
- R7: The raw state of a leg is "high side on" when its reference is strictly greater than the carrier. High and low outputs of a leg are never on together. A reference of 0 keeps the leg on the low side. A reference above the peak keeps it on the high side.
- R8: An output turns on only after the raw state has held for the dead-time count of ticks. With prescale 1, `gate_hi[i]` is 1 in clock k exactly when the raw state was high in each of clocks k-1-D through k-1, all of them at or after the run start, where D is the dead time. `gate_lo[i]` follows the same rule for the raw low state. Turn-off follows on the next clock.
- R9: Out of reset and while stopped, every gate output and both events are 0, the carrier is at 0 and the prescaler is cleared.
- R10: Each event sets its pending bit in the same clock as its pulse. A pending bit stays set until it is cleared through address 8, and a new event wins over a clear in the same clock. `irq` is the OR of the pending bits ANDed with their enables, and it follows both with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 16 | Register write data |
| gate_hi | output | 3 | Upper-switch drive, one bit per leg |
| gate_lo | output | 3 | Lower-switch drive, one bit per leg |
| evt_cmp_down | output | 1 | One-clock compare-down event |
| evt_zero | output | 1 | One-clock cycle-start event |
| irq | output | 1 | Enabled pending events combined |

## Verification
The embedded properties watch every cycle for these behaviours:
- the carrier steps by exactly one, stays within the peak, and holds between ticks;
- events coincide with the carrier values they claim;
- applied references stay frozen away from the zero landing;
- no leg drives both switches;
- a stopped block goes quiet;
- pending bits stay sticky.

The exact turn-on delay, the sample-exact mid-cycle reference handover, the event spacing under prescaling and the interrupt masking and clearing can only be shown by the bench. It sweeps dead times and reference triples, including the out-of-range ones, against an arithmetic model of the triangle.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
// Shared constants and the register address encoding for the PWM generator.
// Assumes a word-addressed write-only register port.
package pwm3_pkg;
    localparam int ADDR_W   = 4;
    localparam int NUM_LEGS = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 4'd0,
        RA_PEAK  = 4'd1,
        RA_PRESC = 4'd2,
        RA_DEAD  = 4'd3,
        RA_CDLVL = 4'd4,
        RA_REF0  = 4'd5,
        RA_REF1  = 4'd6,
        RA_REF2  = 4'd7,
        RA_CLEAR = 4'd8
    } reg_addr_e;

    // control register bit positions
    localparam int CB_RUN   = 0;
    localparam int CB_IE_CD = 1;
    localparam int CB_IE_ZR = 2;
    // pending / clear bit positions
    localparam int PB_CD = 0;
    localparam int PB_ZR = 1;
endpackage

// File: rtl/pwm3_regs.sv
`timescale 1ns/1ps
// Register file: decodes writes, holds the settings and shadow references,
// applies the shadows at the cycle boundary and keeps the sticky pending bits.
// Assumes DATA_W >= CNT_W, PRE_W and DT_W.
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int PRE_W  = 8,
    parameter int DT_W   = 8,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          wrap,
    input  logic                          cd_hit,
    output logic                          run,
    output logic [CNT_W-1:0]              peak,
    output logic [PRE_W-1:0]              presc,
    output logic [DT_W-1:0]               dead,
    output logic [CNT_W-1:0]              cd_lvl,
    output logic [NUM_LEGS-1:0][CNT_W-1:0] ref_act,
    output logic                          irq
);
    logic [2:0]                           ctrl_q;
    logic [NUM_LEGS-1:0][CNT_W-1:0]       ref_shd_q;
    logic [NUM_LEGS-1:0][CNT_W-1:0]       ref_act_q;
    logic [1:0]                           pend_q;
    logic [1:0]                           clr;
    logic [1:0]                           hit;

    assign clr = (wr_en && wr_addr == RA_CLEAR) ? wr_data[1:0] : 2'b00;
    assign hit[PB_CD] = cd_hit;
    assign hit[PB_ZR] = wrap;

    // Settings registers written by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            peak   <= '0;
            presc  <= '0;
            dead   <= '0;
            cd_lvl <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_CTRL:  ctrl_q <= wr_data[2:0];
                RA_PEAK:  peak   <= wr_data[CNT_W-1:0];
                RA_PRESC: presc  <= wr_data[PRE_W-1:0];
                RA_DEAD:  dead   <= wr_data[DT_W-1:0];
                RA_CDLVL: cd_lvl <= wr_data[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    // Shadow and applied references, one pair per leg.
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_ref
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_shd_q[g] <= '0;
                ref_act_q[g] <= '0;
            end else begin
                if (wr_en && wr_addr == ADDR_W'(int'(RA_REF0) + g))
                    ref_shd_q[g] <= wr_data[CNT_W-1:0];
                if (!ctrl_q[CB_RUN] || wrap)
                    ref_act_q[g] <= ref_shd_q[g];
            end
        end
    end

    // Sticky pending bits; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | hit;
    end

    assign run     = ctrl_q[CB_RUN];
    assign ref_act = ref_act_q;
    assign irq     = (pend_q[PB_CD] && ctrl_q[CB_IE_CD]) ||
                     (pend_q[PB_ZR] && ctrl_q[CB_IE_ZR]);

    AST_REF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(ref_act_q)); // R6
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[PB_ZR] && !clr[PB_ZR]) |=> pend_q[PB_ZR]); // R10
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cd_hit |=> pend_q[PB_CD]); // R10
endmodule

// File: rtl/pwm3_carrier.sv
`timescale 1ns/1ps
// Prescaler and symmetric up/down triangle counter with its two events.
// Assumes the peak is changed only while stopped.
module pwm3_carrier #(
    parameter int CNT_W = 12,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] peak,
    input  logic [PRE_W-1:0] presc,
    input  logic [CNT_W-1:0] cd_lvl,
    output logic [CNT_W-1:0] cnt,
    output logic             tick,
    output logic             wrap,
    output logic             cd_hit,
    output logic             evt_cd,
    output logic             evt_zero
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] presc_eff;
    logic [CNT_W-1:0] cnt_q;
    logic             down_q;

    assign presc_eff = (presc == '0) ? PRE_W'(1) : presc;
    assign tick      = run && (pre_q == '0);
    assign wrap      = tick && down_q && (cnt_q == CNT_W'(1));
    assign cd_hit    = tick && down_q && ((cnt_q - CNT_W'(1)) == cd_lvl);

    // Prescaler: one tick every presc_eff clocks while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)                       pre_q <= '0;
        else if (pre_q == presc_eff - PRE_W'(1))  pre_q <= '0;
        else                                      pre_q <= pre_q + PRE_W'(1);
    end

    // Triangle: climb to the peak, then descend to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (tick) begin
            if (peak == '0) begin
                cnt_q  <= '0;
                down_q <= 1'b0;
            end else if (down_q) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) down_q <= 1'b0;
            end else if (cnt_q >= peak) begin
                cnt_q  <= cnt_q - CNT_W'(1);
                down_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (cnt_q + CNT_W'(1) == peak) down_q <= 1'b1;
            end
        end
    end

    // Event pulses aligned with the counter value they mark.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            evt_cd   <= 1'b0;
            evt_zero <= 1'b0;
        end else begin
            evt_cd   <= cd_hit;
            evt_zero <= wrap;
        end
    end

    assign cnt = cnt_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(peak) && $past(cnt_q <= peak)) |-> cnt_q <= peak); // R1
    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && peak != '0) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) ||
                                 (cnt_q == $past(cnt_q) - CNT_W'(1))); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_q)); // R2
    AST_ZERO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_zero |-> cnt_q == '0); // R5
    AST_CD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cd |-> cnt_q == $past(cd_lvl)); // R4
endmodule

// File: rtl/pwm3_deadband.sv
`timescale 1ns/1ps
// One leg's complementary output stage: turn-on waits until the raw
// state has held for the dead-time count of ticks; turn-off is immediate.
// Assumes raw only changes on carrier ticks or at run start.
module pwm3_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic            raw,
    input  logic [DT_W-1:0] dead,
    output logic            hi,
    output logic            lo
);
    logic            last_q;
    logic [DT_W-1:0] held_q;
    logic            settled;

    assign settled = (raw == last_q) ? ({1'b0, held_q} + 1'b1 >= {1'b0, dead})
                                     : (dead == '0);

    // Track raw history and gate the outputs by the settle rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            held_q <= '0;
            hi     <= 1'b0;
            lo     <= 1'b0;
        end else if (!run) begin
            last_q <= !raw;
            held_q <= '0;
            hi     <= 1'b0;
            lo     <= 1'b0;
        end else begin
            last_q <= raw;
            if (raw != last_q)                held_q <= '0;
            else if (tick && held_q < dead)   held_q <= held_q + DT_W'(1);
            hi <= raw && settled;
            lo <= !raw && settled;
        end
    end

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo)); // R7
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!hi && !lo)); // R9
    AST_HI_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi) && $past(dead) != '0) |-> ($past(raw, 1) && $past(raw, 2))); // R8
endmodule

// File: rtl/pwm3_gen.sv
`timescale 1ns/1ps
// Top: three-leg triangle-carrier PWM with dead time, compare-down and
// zero events and a maskable interrupt. Register map in pwm3_pkg.
module pwm3_gen
    import pwm3_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int PRE_W  = 8,
    parameter int DT_W   = 8,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_LEGS-1:0] gate_hi,
    output logic [NUM_LEGS-1:0] gate_lo,
    output logic                evt_cmp_down,
    output logic                evt_zero,
    output logic                irq
);
    logic                           run, tick, wrap, cd_hit;
    logic [CNT_W-1:0]               peak, cd_lvl, cnt;
    logic [PRE_W-1:0]               presc;
    logic [DT_W-1:0]                dead;
    logic [NUM_LEGS-1:0][CNT_W-1:0] ref_act;
    logic [NUM_LEGS-1:0]            raw;

    pwm3_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DT_W(DT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wrap(wrap), .cd_hit(cd_hit), .run(run), .peak(peak), .presc(presc),
        .dead(dead), .cd_lvl(cd_lvl), .ref_act(ref_act), .irq(irq)
    );

    pwm3_carrier #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_carrier (
        .clk(clk), .rst_n(rst_n), .run(run), .peak(peak), .presc(presc),
        .cd_lvl(cd_lvl), .cnt(cnt), .tick(tick), .wrap(wrap), .cd_hit(cd_hit),
        .evt_cd(evt_cmp_down), .evt_zero(evt_zero)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        assign raw[g] = ref_act[g] > cnt;
        pwm3_deadband #(.DT_W(DT_W)) u_db (
            .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .raw(raw[g]),
            .dead(dead), .hi(gate_hi[g]), .lo(gate_lo[g])
        );
    end
endmodule

// File: tb/sim_pwm3_gen.sv
`timescale 1ns/1ps
module sim_pwm3_gen;
    localparam int P  = 10;
    localparam int NK = 6 * P;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  gate_hi, gate_lo;
    logic        evt_cmp_down, evt_zero, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit rh [0:2][0:NK-1];

    pwm3_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .evt_cmp_down(evt_cmp_down),
        .evt_zero(evt_zero), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Write one register; returns at the negedge after the write edge.
    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int tri_at(input int k, input int pk);
        int m = k % (2 * pk);
        return (m <= pk) ? m : 2 * pk - m;
    endfunction

    task automatic scenario(input int dt, input int r0, input int r1, input int r2,
                            input int n0, input int n1, input int n2, input int cd);
        int rold [3];
        int rnew [3];
        bit pend_cd = 0, pend_zr = 0;
        rold[0] = r0; rold[1] = r1; rold[2] = r2;
        rnew[0] = n0; rnew[1] = n1; rnew[2] = n2;
        wr(0, 0); wr(1, P); wr(2, 1); wr(3, dt); wr(4, cd);
        wr(5, r0); wr(6, r1); wr(7, r2); wr(8, 3);
        wr(0, 7);
        for (int k = 0; k < NK; k++) begin
            int t = tri_at(k, P);
            int eh = 0, el = 0;
            bit ez, ec;
            for (int i = 0; i < 3; i++) begin
                int a = (k >= 2 * P) ? rnew[i] : rold[i];
                rh[i][k] = (a > t);
            end
            for (int i = 0; i < 3; i++) begin
                bit allh = 1, alll = 1;
                if (k < 1 || k - 1 - dt < 0) begin
                    allh = 0; alll = 0;
                end else begin
                    for (int j = k - 1 - dt; j <= k - 1; j++) begin
                        if (!rh[i][j]) allh = 0;
                        if (rh[i][j])  alll = 0;
                    end
                end
                eh |= int'(allh) << i;
                el |= int'(alll) << i;
            end
            check("R8/R7/R6 gate_hi", int'(gate_hi), eh);
            check("R8/R7/R6 gate_lo", int'(gate_lo), el);
            ez = (k > 0) && (k % (2 * P) == 0);
            ec = (k > 0) && (t == cd) && ((k % (2 * P) > P) || (k % (2 * P) == 0));
            check("R5 evt_zero", int'(evt_zero), int'(ez));
            check("R4 evt_cmp_down", int'(evt_cmp_down), int'(ec));
            pend_cd |= ec; pend_zr |= ez;
            check("R10 irq while enabled", int'(irq), int'(pend_cd | pend_zr));
            if (k >= P && k < P + 3) begin
                wr_en = 1'b1; wr_addr = 4'(5 + k - P); wr_data = 16'(rnew[k - P]);
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        wr(0, 0);
        @(negedge clk);
        check("R9 stopped gate_hi", int'(gate_hi), 0);
        check("R9 stopped gate_lo", int'(gate_lo), 0);
        check("R9 stopped events", int'(evt_zero) + int'(evt_cmp_down), 0);
        check("R10 masked irq", int'(irq), 0);
        wr(0, 6);
        check("R10 unmasked pending", int'(irq), 1);
        wr(8, 3);
        check("R10 cleared irq", int'(irq), 0);
    endtask

    // Run with given peak/prescale; return the clocks of the first two zero events.
    task automatic zero_times(input int pk, input int ps, output int z1, output int z2);
        z1 = -1; z2 = -1;
        wr(0, 0); wr(1, pk); wr(2, ps); wr(3, 0);
        wr(0, 1);
        for (int k = 0; k < 80; k++) begin
            if (evt_zero) begin
                if (z1 < 0) z1 = k;
                else if (z2 < 0) z2 = k;
            end
            @(negedge clk);
        end
        wr(0, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int z1, z2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset gate_hi", int'(gate_hi), 0);
        check("R9 reset gate_lo", int'(gate_lo), 0);
        check("R9 reset events", int'(evt_zero) + int'(evt_cmp_down), 0);
        check("R10 reset irq", int'(irq), 0);
        // R3 map used throughout; R7 boundaries: refs 0 and above peak
        for (int dt = 0; dt < 4; dt++) begin
            for (int s = 0; s <= P; s++) begin
                scenario(dt, s, P - s, (s * 3) % (P + 2),
                         (s + 4) % (P + 1), s / 2, P + 3 - (s % 3),
                         1 + (s % (P - 1)));
            end
        end
        // R1/R2: cycle length and prescale
        zero_times(4, 1, z1, z2);
        check("R1 first zero, prescale 1", z1, 8);
        check("R1 zero spacing", z2 - z1, 8);
        zero_times(4, 3, z1, z2);
        check("R2 first zero, prescale 3", z1, 22);
        check("R2 zero spacing, prescale 3", z2 - z1, 24);
        zero_times(4, 0, z1, z2);
        check("R2 prescale 0 acts as 1", z2 - z1, 8);
        zero_times(1, 1, z1, z2);
        check("R1 peak 1 cycle", z2 - z1, 2);
        zero_times(0, 1, z1, z2);
        check("R1 peak 0 never wraps", z1, -1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule